// File: doc/BRIEF.md
# Asynchronous SRAM Write-Strobe Controller

This block lets a small 32-word by 8-bit logical memory live in an external asynchronous static RAM. The external part has a 20-bit address bus and a 16-bit bidirectional data bus. The controller runs on a single clock that is meant to be 50 MHz (20 ns period). It holds the chip-select, output-enable and both byte-lane controls permanently active, and it tells reads and writes apart only through the active-low write strobe. Every unused address line and the upper data byte are tied to zero.

On the user side, the address, write data and write request are registered on every clock edge. A write is a two-cycle operation. In the first cycle the controller places the address and padded data and pulls the strobe low. In the second cycle it releases the strobe while the address stays put. The controller drives the data bus only while the strobe is low, so it never fights the memory's output drivers. The memory commits the word on the rising edge of the strobe, which gives a full clock period of address and data setup. When no write is in progress, the address follows the user address. The low byte of the bus is captured one full clock period after the address is presented, which leaves ample margin over the memory's 10 ns access time.

If a write request arrives while the strobe is low, it is parked in a one-entry holding slot. It is issued as soon as the strobe has returned high.

Top module: `asramCtrl`

## Requirements
- R1: The active-low chip-select, output-enable, upper-byte and lower-byte outputs are 0 in every cycle, including during reset.
- R2: memAddr[19:5] is always 0, and memAddr[4:0] carries the 5-bit user address of the current operation.
- R3: A write request sampled at clock edge k pulls memWeN low at edge k+1 for exactly one clock cycle. At that same edge, memAddr is set to the request address and memDq is driven with {8'h00, data}.
- R4: At the edge where memWeN returns high, memAddr does not change. The write address is held for the whole cycle after the low pulse.
- R5: The controller drives memDq only while memWeN is low. In every other cycle, including reset, memDq is high-impedance and carries the memory's own output.
- R6: In a cycle without a write, a user address sampled at edge k appears on memAddr at edge k+1. rdData then shows memDq[7:0] of that word from edge k+2. rdData does not change at an edge that ends a strobe-low cycle.
- R7: A write request sampled at the edge that ends a strobe-low cycle is not lost. After one cycle with memWeN high, memWeN goes low again with that request's address and data.
- R8: During reset, memWeN is 1, memAddr is 0 and rdData is 0.
- R9: A read of an address returns the byte most recently written there, and the upper byte of the stored word never reaches rdData.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, 20 ns nominal |
| rstN | input | 1 | Active-low synchronous reset |
| reqAddr | input | 5 | User word address |
| reqData | input | 8 | User write data |
| reqWrite | input | 1 | Write request, sampled every edge |
| rdData | output | 8 | Byte read from the current address |
| memAddr | output | 20 | Address to the external memory |
| memDq | inout | 16 | Bidirectional memory data bus |
| memCeN | output | 1 | Chip select, active low, held at 0 |
| memOeN | output | 1 | Output enable, active low, held at 0 |
| memWeN | output | 1 | Write strobe, active low |
| memUbN | output | 1 | Upper byte lane enable, active low, held at 0 |
| memLbN | output | 1 | Lower byte lane enable, active low, held at 0 |

## Verification
A controller stuck in the strobe-low state shows up one cycle later: memWeN stays low for two edges and the bus keeps being driven. A dropped holding slot shows up as a missing second low pulse two cycles after the first. An address register that moves at the strobe's rising edge is visible on memAddr in that same cycle. The write would then land at the wrong word, and the next read-back, three cycles later, returns the wrong byte. A read-capture register enabled in the wrong cycle shifts the rdData update by one edge against the two-edge latency.

// File: rtl/asramPkg.sv
package asramPkg;

  typedef enum logic {
    ST_IDLE,
    ST_LOW
  } ctlState_e;

  // Strobes from the control FSM to the datapath, valid for one cycle
  typedef struct packed {
    logic launch;    // start a write: load address/data, pull strobe low
    logic fromPend;  // launch uses the holding slot instead of the input regs
    logic stash;     // copy the registered request into the holding slot
    logic dropPend;  // empty the holding slot
    logic track;     // memory address follows the registered user address
    logic raise;     // return the strobe high and release the bus
    logic sampleRd;  // capture the low byte of the bus
  } ctlStrobes_t;

endpackage

// File: rtl/asramCtrlFsm.sv
module asramCtrlFsm
  import asramPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inWr,
  input  logic        pendValid,
  output ctlStrobes_t strb
);

  ctlState_e curState;
  ctlState_e nextState;

  always_comb begin
    strb      = '0;
    nextState = curState;
    unique case (curState)
      ST_IDLE: begin
        strb.sampleRd = 1'b1;
        if (pendValid) begin
          strb.launch   = 1'b1;
          strb.fromPend = 1'b1;
          if (inWr) strb.stash    = 1'b1;
          else      strb.dropPend = 1'b1;
          nextState = ST_LOW;
        end else if (inWr) begin
          strb.launch = 1'b1;
          nextState   = ST_LOW;
        end else begin
          strb.track = 1'b1;
        end
      end
      ST_LOW: begin
        strb.raise = 1'b1;
        if (inWr) strb.stash = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) curState <= ST_IDLE;
    else       curState <= nextState;
  end

  // A request seen while the strobe is low must be parked in the slot
  AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_LOW && inWr) |=> pendValid); // R7

  // A parked request is issued as soon as the strobe is high again
  AST_PEND_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE && pendValid) |=> (curState == ST_LOW)); // R7

endmodule

// File: rtl/asramDatapath.sv
module asramDatapath
  import asramPkg::*;
#(
  parameter int USER_AW = 5,
  parameter int USER_DW = 8,
  parameter int MEM_AW  = 20,
  parameter int MEM_DW  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strb,
  input  logic [USER_AW-1:0] reqAddr,
  input  logic [USER_DW-1:0] reqData,
  input  logic               reqWrite,
  input  logic [USER_DW-1:0] busLowIn,
  output logic               inWr,
  output logic               pendValid,
  output logic [MEM_AW-1:0]  memAddrOut,
  output logic [MEM_DW-1:0]  wrWord,
  output logic               driveBus,
  output logic               weNOut,
  output logic [USER_DW-1:0] rdDataOut
);

  localparam int ADDR_PAD = MEM_AW - USER_AW;
  localparam int DATA_PAD = MEM_DW - USER_DW;

  logic [USER_AW-1:0] inAddr, pendAddr, memAddrQ;
  logic [USER_DW-1:0] inData, pendData, wdQ, rdQ;
  logic               weNQ, drvQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inAddr    <= '0;
      inData    <= '0;
      inWr      <= 1'b0;
      pendAddr  <= '0;
      pendData  <= '0;
      pendValid <= 1'b0;
      memAddrQ  <= '0;
      wdQ       <= '0;
      weNQ      <= 1'b1;
      drvQ      <= 1'b0;
      rdQ       <= '0;
    end else begin
      inAddr <= reqAddr;
      inData <= reqData;
      inWr   <= reqWrite;

      if (strb.launch) begin
        memAddrQ <= strb.fromPend ? pendAddr : inAddr;
        wdQ      <= strb.fromPend ? pendData : inData;
        weNQ     <= 1'b0;
        drvQ     <= 1'b1;
      end else if (strb.track) begin
        memAddrQ <= inAddr;
      end

      if (strb.raise) begin
        weNQ <= 1'b1;
        drvQ <= 1'b0;
      end

      if (strb.stash) begin
        pendValid <= 1'b1;
        pendAddr  <= inAddr;
        pendData  <= inData;
      end else if (strb.dropPend) begin
        pendValid <= 1'b0;
      end

      if (strb.sampleRd) rdQ <= busLowIn;
    end
  end

  assign memAddrOut = {{ADDR_PAD{1'b0}}, memAddrQ};
  assign wrWord     = {{DATA_PAD{1'b0}}, wdQ};
  assign driveBus   = drvQ;
  assign weNOut     = weNQ;
  assign rdDataOut  = rdQ;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    !weNQ |=> weNQ); // R3

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weNQ) |-> $stable(memAddrQ)); // R4

  AST_DRIVE_ONLY_LOW: assert property (@(posedge clk) disable iff (!rstN)
    drvQ |-> !weNQ); // R5

  AST_NO_READ_WHILE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !weNQ |=> $stable(rdQ)); // R6

endmodule

// File: rtl/asramCtrl.sv
module asramCtrl
  import asramPkg::*;
#(
  parameter int USER_AW = 5,
  parameter int USER_DW = 8,
  parameter int MEM_AW  = 20,
  parameter int MEM_DW  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [USER_AW-1:0] reqAddr,
  input  logic [USER_DW-1:0] reqData,
  input  logic               reqWrite,
  output logic [USER_DW-1:0] rdData,
  output logic [MEM_AW-1:0]  memAddr,
  inout  wire  [MEM_DW-1:0]  memDq,
  output logic               memCeN,
  output logic               memOeN,
  output logic               memWeN,
  output logic               memUbN,
  output logic               memLbN
);

  ctlStrobes_t       strb;
  logic              inWr;
  logic              pendValid;
  logic              driveBus;
  logic [MEM_DW-1:0] wrWord;

  asramCtrlFsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .inWr      (inWr),
    .pendValid (pendValid),
    .strb      (strb)
  );

  asramDatapath #(
    .USER_AW (USER_AW),
    .USER_DW (USER_DW),
    .MEM_AW  (MEM_AW),
    .MEM_DW  (MEM_DW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .reqWrite   (reqWrite),
    .busLowIn   (memDq[USER_DW-1:0]),
    .inWr       (inWr),
    .pendValid  (pendValid),
    .memAddrOut (memAddr),
    .wrWord     (wrWord),
    .driveBus   (driveBus),
    .weNOut     (memWeN),
    .rdDataOut  (rdData)
  );

  assign memDq  = driveBus ? wrWord : {MEM_DW{1'bz}};
  assign memCeN = 1'b0;
  assign memOeN = 1'b0;
  assign memUbN = 1'b0;
  assign memLbN = 1'b0;

endmodule

// File: tb/asramCtrl_tb_top.sv
module asramCtrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  reqAddr = '0;
  logic [7:0]  reqData = '0;
  logic        reqWrite = 1'b0;
  logic [7:0]  rdData;
  logic [19:0] memAddr;
  wire  [15:0] memDq;
  logic        memCeN, memOeN, memWeN, memUbN, memLbN;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  asramCtrl dut_i (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqData(reqData),
    .reqWrite(reqWrite), .rdData(rdData), .memAddr(memAddr), .memDq(memDq),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memUbN(memUbN), .memLbN(memLbN)
  );

  // Behavioural memory: drives the bus while the strobe is high,
  // commits the word at the edge where the strobe returns high.
  logic [15:0] mem [32];
  logic [15:0] memOut;
  assign memOut = mem[memAddr[4:0]];
  assign memDq  = memWeN ? memOut : 16'hzzzz;

  always @(posedge clk)
    if (rstN && !memWeN) mem[memAddr[4:0]] <= memDq;

  initial
    for (int i = 0; i < 32; i++) mem[i] = {8'h5A, 8'(i * 7 + 3)};

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  // R3 and R2 padding: whenever the strobe is low the upper byte is zero
  always @(negedge clk)
    if (rstN && !memWeN) begin
      chk("R3 upper byte zero while writing", {12'h0, memDq[15:8]}, 20'h0);
      chk("R2 upper address zero", {5'h0, memAddr[19:5]}, 20'h0);
    end

  task automatic doWrite(input logic [4:0] a, input logic [7:0] d);
    reqWrite = 1'b1; reqAddr = a; reqData = d;
    tick();
    reqWrite = 1'b0;
    tick();
    tick();
  endtask

  task automatic doRead(input logic [4:0] a, output logic [7:0] d);
    reqAddr = a;
    tick(); tick(); tick();
    d = rdData;
  endtask

  // {write, addr[4:0], data[7:0], expected read[7:0]}
  localparam logic [21:0] VEC [8] = '{
    {1'b1, 5'd5,  8'h3C, 8'h3C},
    {1'b1, 5'd31, 8'hFF, 8'hFF},
    {1'b0, 5'd0,  8'h00, 8'h03},
    {1'b0, 5'd3,  8'h00, 8'h18},
    {1'b1, 5'd0,  8'h00, 8'h00},
    {1'b1, 5'd5,  8'hC3, 8'hC3},
    {1'b0, 5'd31, 8'h00, 8'hFF},
    {1'b0, 5'd16, 8'h00, 8'h73}
  };

  initial begin
    logic [7:0] got;
    @(negedge clk);
    tick(); tick(); tick();
    // Reset state
    chk("R8 strobe high in reset", {19'h0, memWeN}, 20'h1);
    chk("R8 address zero in reset", memAddr, 20'h0);
    chk("R8 rdData zero in reset", {12'h0, rdData}, 20'h0);
    chk("R5 bus released in reset", {4'h0, memDq}, 20'h05A03);
    chk("R1 control pins low", {16'h0, memCeN, memOeN, memUbN, memLbN}, 20'h0);
    rstN = 1'b1;
    tick(); tick();

    // Vector table: write then read back, or plain read (R9, R6)
    for (int v = 0; v < 8; v++) begin
      if (VEC[v][21]) doWrite(VEC[v][20:16], VEC[v][15:8]);
      doRead(VEC[v][20:16], got);
      chk("R9 read-back", {12'h0, got}, {12'h0, VEC[v][7:0]});
    end

    // Strobe sequencing on one write (R3, R4, R5, R9)
    reqWrite = 1'b1; reqAddr = 5'd4; reqData = 8'h9E;
    tick();
    chk("R3 strobe not yet low", {19'h0, memWeN}, 20'h1);
    reqWrite = 1'b0;
    tick();
    chk("R3 strobe low", {19'h0, memWeN}, 20'h0);
    chk("R3 address with strobe", memAddr, 20'h00004);
    chk("R3 padded data driven", {4'h0, memDq}, 20'h0009E);
    tick();
    chk("R3 strobe low one cycle only", {19'h0, memWeN}, 20'h1);
    chk("R4 address held after rise", memAddr, 20'h00004);
    chk("R5 bus from memory after rise", {4'h0, memDq}, 20'h0009E);
    tick();
    chk("R9 written byte read back", {12'h0, rdData}, 20'h0009E);

    // Read latency (R6)
    reqAddr = 5'd9;
    tick();
    chk("R6 address not yet moved", memAddr, 20'h00004);
    tick();
    chk("R6 address presented", memAddr, 20'h00009);
    chk("R6 rdData not yet updated", {12'h0, rdData}, 20'h0009E);
    tick();
    chk("R6 rdData after two edges", {12'h0, rdData}, 20'h00042);

    // Request during the low cycle is parked and issued (R7)
    reqWrite = 1'b1; reqAddr = 5'd12; reqData = 8'h11;
    tick();
    reqAddr = 5'd13; reqData = 8'h22;
    tick();
    chk("R7 first pulse low", {19'h0, memWeN}, 20'h0);
    chk("R7 first address", memAddr, 20'h0000C);
    reqWrite = 1'b0;
    tick();
    chk("R7 gap with strobe high", {19'h0, memWeN}, 20'h1);
    chk("R4 first address held", memAddr, 20'h0000C);
    tick();
    chk("R7 parked write issued", {19'h0, memWeN}, 20'h0);
    chk("R7 parked address", memAddr, 20'h0000D);
    chk("R7 parked data", {4'h0, memDq}, 20'h00022);
    tick();
    chk("R7 second pulse ends", {19'h0, memWeN}, 20'h1);
    doRead(5'd12, got);
    chk("R7 first word stored", {12'h0, got}, 20'h00011);
    doRead(5'd13, got);
    chk("R7 parked word stored", {12'h0, got}, 20'h00022);
    chk("R1 control pins low after traffic", {16'h0, memCeN, memOeN, memUbN, memLbN}, 20'h0);

    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

endmodule